// File: doc/BRIEF.md
# Centre-Aligned PWM Timebase with Event Actions

This block drives two PWM outputs from a triangle counter. The counter climbs from zero to a programmed period, turns, descends back to zero and starts over, so every period spans twice the period value in clock cycles. Two compare values are checked against the counter. Each output has its own table of action codes, one code for each counter event. The events are the counter reaching zero, and a match with either compare value while counting up or while counting down. A code can drive the output high, drive it low, invert it, or leave it alone.

The period and both compare values are written into holding registers. They reach the working registers only when the counter is at zero, so a new duty or frequency never cuts a period short. Several instances can share one global run enable, so they can be set up while frozen and started in the same cycle. A sync input can preset the counter to a phase value, and the sync output either marks this block's zero point or forwards the incoming sync, so instances can be chained. A strobe marks every zero point for an interrupt controller.

Top module: `pwm_updown_aq`

## Requirements
- R1: While `tb_en` is high and the working period P is nonzero, `count` follows 0,1,…,P,P−1,…,1,0 and repeats, one step per cycle. A period is 2P cycles. While P is zero and `count` is 0, the counter holds at 0. A counter above P counts down.
- R2: A write to the period holding register takes effect at the next cycle in which `count` is 0 with `tb_en` high. The period in progress keeps its old length.
- R3: Compare A and compare B are written into holding registers and copied into the working registers at each zero point. The holding value used is the one present before that edge.
- R4: `act_a` and `act_b` each hold five 2-bit codes: bits [1:0] zero, [3:2] compare-A-up, [5:4] compare-A-down, [7:6] compare-B-up, [9:8] compare-B-down. The code values are 00 no action, 01 drive low, 10 drive high, 11 invert. The output register changes on the clock edge at which the event's counter value is present. A match at count 0 counts as up. A match at count P counts as down.
- R5: With A set at zero and cleared on compare-A-up, and B set at zero and cleared on compare-A-down, compare value C and period P give A high for C cycles and B high for 2P−C cycles of each period.
- R6: `sync_out` equals `zero_irq` when `sync_master` is 1 and equals `sync_in` when it is 0, in the same cycle.
- R7: With `tb_en` high and `phase_en` high, `sync_in` loads `phase_val` into the counter on the next edge and sets the direction to up. With `phase_en` low, `sync_in` has no effect on the count.
- R8: While `tb_en` is low, the counter, both outputs and the working registers hold, and `zero_irq` stays low.
- R9: `zero_irq` is high in exactly those cycles in which `tb_en` is high and `count` is 0.
- R10: `cnt_wr` loads `cnt_wdata` into the counter on the next edge regardless of `tb_en`, and the next count step goes up.
- R11: When events coincide, the highest-priority event with a code other than 00 decides. Compare A ranks above compare B, which ranks above zero.
- R12: After reset, `count`, `pwm_a`, `pwm_b` and all period and compare registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | Global run enable for the counter |
| sync_in | input | 1 | Sync strobe from a neighbour |
| sync_master | input | 1 | 1: sync_out marks zero; 0: sync_out forwards sync_in |
| phase_en | input | 1 | Allow sync_in to preset the counter |
| phase_val | input | CNT_W | Preset value loaded on sync |
| prd_wr | input | 1 | Write strobe for period holding register |
| prd_wdata | input | CNT_W | Period value |
| cmpa_wr | input | 1 | Write strobe for compare A holding register |
| cmpa_wdata | input | CNT_W | Compare A value |
| cmpb_wr | input | 1 | Write strobe for compare B holding register |
| cmpb_wdata | input | CNT_W | Compare B value |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_wdata | input | CNT_W | Direct counter value |
| act_a | input | 10 | Action codes for output A |
| act_b | input | 10 | Action codes for output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| sync_out | output | 1 | Sync output |
| zero_irq | output | 1 | Zero-point strobe |
| count | output | CNT_W | Current counter value |

## Verification
The complementary setting (set at zero, clear on a compare match while rising for A and while falling for B) is measured per period. The high-cycle counts C and 2P−C tell the up and down match directions apart and catch off-by-one errors in the output timing. Writes placed in the middle of a period show whether the holding registers wait for the zero point. A compare value of zero and an invert-at-zero code exercise event priority and the invert code. Random stimulus then mixes frozen spans, phase presets, direct writes, period zero and random code tables against a bench reference model, and checks every output each cycle.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int N_EVT  = 5;
  localparam int N_CMP  = 2;
  localparam int EV_ZERO = 0;
  localparam int EV_CAU  = 1;
  localparam int EV_CAD  = 2;
  localparam int EV_CBU  = 3;
  localparam int EV_CBD  = 4;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_code_e;

  // New output level for one code.
  function automatic logic apply_code(input logic cur, input logic [1:0] code);
    case (act_code_e'(code))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction

  // Zero lowest, then compare B, compare A highest; code 00 never masks.
  function automatic logic [1:0] pick_code(input logic [N_EVT-1:0] ev,
                                           input logic [2*N_EVT-1:0] acts);
    logic [1:0] c;
    c = 2'b00;
    if (ev[EV_ZERO] && acts[1:0] != 2'b00) c = acts[1:0];
    for (int i = N_EVT - 1; i >= 1; i--) begin
      if (ev[i] && acts[2*i +: 2] != 2'b00) c = acts[2*i +: 2];
    end
    return c;
  endfunction
endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] shd,
  output logic [W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
      act <= '0;
    end else begin
      if (wr)   shd <= wdata;
      if (load) act <= shd;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic [CNT_W-1:0] prd,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             sync_in,
  input  logic             phase_en,
  input  logic [CNT_W-1:0] phase_val,
  output logic [CNT_W-1:0] count,
  output logic             cnt_up,
  output logic             zero_ev
);
  logic dir_up;
  logic parked;

  function automatic logic next_up(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] p,
                                   input logic d);
    if (c == '0)     return 1'b1;
    else if (c >= p) return 1'b0;
    else             return d;
  endfunction

  assign cnt_up  = next_up(count, prd, dir_up);
  assign parked  = (count == '0) && (prd == '0);
  assign zero_ev = tb_en && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (cnt_wr) begin
      count  <= cnt_wdata;
      dir_up <= 1'b1;
    end else if (tb_en) begin
      if (sync_in && phase_en) begin
        count  <= phase_val;
        dir_up <= 1'b1;
      end else if (!parked) begin
        count  <= cnt_up ? count + 1'b1 : count - 1'b1;
        dir_up <= cnt_up;
      end
    end
  end
endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
  import pwm_aq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EVT-1:0]   ev,
  input  logic [2*N_EVT-1:0] acts,
  output logic               pwm
);
  logic [1:0] code;
  assign code = pick_code(ev, acts);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= apply_code(pwm, code);
  end
endmodule

// File: rtl/pwm_updown_aq.sv
module pwm_updown_aq
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             sync_in,
  input  logic             sync_master,
  input  logic             phase_en,
  input  logic [CNT_W-1:0] phase_val,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_wdata,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             cmpb_wr,
  input  logic [CNT_W-1:0] cmpb_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [9:0]       act_a,
  input  logic [9:0]       act_b,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             sync_out,
  output logic             zero_irq,
  output logic [CNT_W-1:0] count
);
  localparam int ACT_W = 2 * N_EVT;

  logic             zero_ev;
  logic             cnt_up;
  logic [CNT_W-1:0] prd_shd, prd_act;
  logic             cmp_wr    [N_CMP];
  logic [CNT_W-1:0] cmp_wdata [N_CMP];
  logic [CNT_W-1:0] cmp_shd   [N_CMP];
  logic [CNT_W-1:0] cmp_act   [N_CMP];
  logic             cmp_hit   [N_CMP];
  logic [N_EVT-1:0] evt;

  assign cmp_wr[0]    = cmpa_wr;
  assign cmp_wr[1]    = cmpb_wr;
  assign cmp_wdata[0] = cmpa_wdata;
  assign cmp_wdata[1] = cmpb_wdata;

  pwm_shadow_reg #(.W(CNT_W)) u_prd (
    .clk(clk), .rst_n(rst_n), .wr(prd_wr), .wdata(prd_wdata),
    .load(zero_ev), .shd(prd_shd), .act(prd_act)
  );

  generate
    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      pwm_shadow_reg #(.W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr[k]), .wdata(cmp_wdata[k]),
        .load(zero_ev), .shd(cmp_shd[k]), .act(cmp_act[k])
      );
      assign cmp_hit[k] = (count == cmp_act[k]);
      assign evt[EV_CAU + 2*k] = tb_en && cmp_hit[k] && cnt_up;
      assign evt[EV_CAD + 2*k] = tb_en && cmp_hit[k] && !cnt_up;
    end
  endgenerate

  assign evt[EV_ZERO] = zero_ev;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .prd(prd_act),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .sync_in(sync_in),
    .phase_en(phase_en), .phase_val(phase_val),
    .count(count), .cnt_up(cnt_up), .zero_ev(zero_ev)
  );

  pwm_aq_out u_out_a (
    .clk(clk), .rst_n(rst_n), .ev(evt), .acts(act_a[ACT_W-1:0]), .pwm(pwm_a)
  );
  pwm_aq_out u_out_b (
    .clk(clk), .rst_n(rst_n), .ev(evt), .acts(act_b[ACT_W-1:0]), .pwm(pwm_b)
  );

  assign zero_irq = zero_ev;
  assign sync_out = sync_master ? zero_ev : sync_in;
endmodule

// File: rtl/pwm_updown_aq_chk.sv
module pwm_updown_aq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tb_en,
  input logic             sync_in,
  input logic             phase_en,
  input logic [CNT_W-1:0] phase_val,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] count,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             zero_irq,
  input logic [CNT_W-1:0] prd_shd,
  input logic [CNT_W-1:0] prd_act,
  input logic [CNT_W-1:0] cmpa_shd,
  input logic [CNT_W-1:0] cmpa_act
);
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && !cnt_wr && !(sync_in && phase_en)) |=>
      (count == $past(count) + CNT_W'(1) || count == $past(count) - CNT_W'(1)
       || count == $past(count)));

  a_r2_prd_load: assert property (@(posedge clk) disable iff (!rst_n)
    zero_irq |=> (prd_act == $past(prd_shd)));

  a_r3_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    zero_irq |=> (cmpa_act == $past(cmpa_shd)));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && !cnt_wr) |=> ($stable(count) && $stable(pwm_a) && $stable(pwm_b)));

  a_r7_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && sync_in && phase_en && !cnt_wr) |=> (count == $past(phase_val)));

  a_r10_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(cnt_wdata)));
endmodule

bind pwm_updown_aq pwm_updown_aq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
  .phase_en(phase_en), .phase_val(phase_val), .cnt_wr(cnt_wr),
  .cnt_wdata(cnt_wdata), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .zero_irq(zero_irq), .prd_shd(prd_shd), .prd_act(prd_act),
  .cmpa_shd(cmp_shd[0]), .cmpa_act(cmp_act[0])
);

// File: tb/test_pwm_updown_aq.sv
module test_pwm_updown_aq;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_en = 1'b0, sync_in = 1'b0, sync_master = 1'b1, phase_en = 1'b0;
  logic [CW-1:0] phase_val = '0, prd_wdata = '0, cmpa_wdata = '0, cmpb_wdata = '0, cnt_wdata = '0;
  logic prd_wr = 1'b0, cmpa_wr = 1'b0, cmpb_wr = 1'b0, cnt_wr = 1'b0;
  logic [9:0] act_a = '0, act_b = '0;
  logic pwm_a, pwm_b, sync_out, zero_irq;
  logic [CW-1:0] count;

  pwm_updown_aq #(.CNT_W(CW)) i_pwm_updown_aq (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .sync_in(sync_in),
    .sync_master(sync_master), .phase_en(phase_en), .phase_val(phase_val),
    .prd_wr(prd_wr), .prd_wdata(prd_wdata), .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
    .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .act_a(act_a), .act_b(act_b), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .sync_out(sync_out), .zero_irq(zero_irq), .count(count)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, built from the requirements.
  int m_cnt, m_prd, m_prd_h, m_ca, m_ca_h, m_cb, m_cb_h;
  bit m_up, m_a, m_b;

  function automatic bit f_goes_up(int c, int p, bit d);
    if (c == 0) return 1;
    if (c >= p) return 0;
    return d;
  endfunction

  function automatic bit f_out(bit cur, bit [4:0] ev, logic [9:0] acts);
    int order[5] = '{1, 2, 3, 4, 0};  // highest priority first
    for (int k = 0; k < 5; k++) begin
      int e = order[k];
      bit [1:0] cd = acts[2*e +: 2];
      if (ev[e] && cd != 2'b00)
        return (cd == 2'b01) ? 1'b0 : (cd == 2'b10) ? 1'b1 : !cur;
    end
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_prd_h = 0; m_ca = 0; m_ca_h = 0; m_cb = 0; m_cb_h = 0;
      m_up = 1; m_a = 0; m_b = 0;
    end else begin
      bit z, u;
      bit [4:0] ev;
      z = tb_en && m_cnt == 0;
      u = f_goes_up(m_cnt, m_prd, m_up);
      ev = '0;
      ev[0] = z;
      ev[1] = tb_en && m_cnt == m_ca && u;
      ev[2] = tb_en && m_cnt == m_ca && !u;
      ev[3] = tb_en && m_cnt == m_cb && u;
      ev[4] = tb_en && m_cnt == m_cb && !u;
      m_a = f_out(m_a, ev, act_a);
      m_b = f_out(m_b, ev, act_b);
      if (cnt_wr) begin
        m_cnt = int'(cnt_wdata); m_up = 1;
      end else if (tb_en) begin
        if (sync_in && phase_en) begin
          m_cnt = int'(phase_val); m_up = 1;
        end else if (!(m_cnt == 0 && m_prd == 0)) begin
          m_cnt = u ? m_cnt + 1 : m_cnt - 1; m_up = u;
        end
      end
      if (z) begin m_prd = m_prd_h; m_ca = m_ca_h; m_cb = m_cb_h; end
      if (prd_wr)  m_prd_h = int'(prd_wdata);
      if (cmpa_wr) m_ca_h  = int'(cmpa_wdata);
      if (cmpb_wr) m_cb_h  = int'(cmpb_wdata);
    end
  end

  task automatic cmp_model();
    bit mz;
    mz = tb_en && m_cnt == 0;
    chk("R1 count", int'(count), m_cnt);
    chk("R4 pwm_a", int'(pwm_a), int'(m_a));
    chk("R4 pwm_b", int'(pwm_b), int'(m_b));
    chk("R9 zero_irq", int'(zero_irq), int'(mz));
    chk("R6 sync_out", int'(sync_out), int'(sync_master ? mz : sync_in));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_model();
    prd_wr = 0; cmpa_wr = 0; cmpb_wr = 0; cnt_wr = 0; sync_in = 0;
  endtask

  // kind: 0 none, 1 compare A write, 2 period write, placed mid-period
  task automatic measure(input int kind, input int val, output int n, output int ha, output int hb);
    int guard = 0;
    while (!zero_irq && guard < 200) begin cyc(); guard++; end
    n = 0; ha = 0; hb = 0;
    do begin
      if (n == 3 && kind == 1) begin cmpa_wr = 1; cmpa_wdata = CW'(val); end
      if (n == 3 && kind == 2) begin prd_wr = 1; prd_wdata = CW'(val); end
      cyc();
      n++; ha += int'(pwm_a); hb += int'(pwm_b);
    end while (!zero_irq && n < 200);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n, ha, hb, ha2, hb2, c0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R12 reset count", int'(count), 0);
    chk("R12 reset pwm_a", int'(pwm_a), 0);
    chk("R12 reset pwm_b", int'(pwm_b), 0);
    chk("R12 reset irq", int'(zero_irq), 0);
    rst_n = 1;
    @(negedge clk);

    // Complementary setting: A high at zero, low on CA up; B high at zero, low on CA down.
    act_a = 10'b00_00_00_01_10;
    act_b = 10'b00_00_01_00_10;
    prd_wr = 1; prd_wdata = 8; cmpa_wr = 1; cmpa_wdata = 3;
    cyc();
    tb_en = 1;
    repeat (20) cyc();
    measure(0, 0, n, ha, hb);
    chk("R1 period length 2P", n, 16);
    chk("R9 irq spacing", n, 16);
    chk("R5 A high cycles C", ha, 3);
    chk("R5 B high cycles 2P-C", hb, 13);

    // R3: compare written mid-period waits for the zero point.
    measure(1, 5, n, ha, hb);
    chk("R3 old compare kept", ha, 3);
    measure(0, 0, n, ha, hb);
    chk("R3 new compare active", ha, 5);
    chk("R3 B with new compare", hb, 11);

    // R2: period written mid-period waits for the zero point.
    measure(2, 6, n, ha, hb);
    chk("R2 old period kept", n, 16);
    measure(0, 0, n, ha, hb);
    chk("R2 new period active", n, 12);

    // R8 / R10: freeze while descending, write counter, restart goes up.
    while (int'(count) != 6) cyc();
    cyc();
    chk("R1 descend after P", int'(count), 5);
    tb_en = 0;
    c0 = int'(count);
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk("R8 frozen count", int'(count), c0);
      chk("R8 no irq while frozen", int'(zero_irq), 0);
    end
    cnt_wr = 1; cnt_wdata = 2;
    cyc();
    chk("R10 counter written while frozen", int'(count), 2);
    tb_en = 1;
    cyc();
    chk("R10 counts up after write", int'(count), 3);
    cyc();
    chk("R10 counts up after write", int'(count), 4);

    // R7: phase preset and ignored sync.
    phase_en = 1; phase_val = 4; sync_in = 1;
    cyc();
    chk("R7 phase loaded", int'(count), 4);
    phase_en = 0; sync_in = 1;
    cyc();
    chk("R7 sync ignored without phase enable", int'(count), 5);

    // R6: slave forwards sync_in in the same cycle.
    sync_master = 0; sync_in = 1;
    @(negedge clk);
    chk("R6 slave forwards high", int'(sync_out), 1);
    sync_in = 0;
    #1;
    chk("R6 slave forwards low", int'(sync_out), 0);
    sync_master = 1;
    while (!zero_irq) cyc();
    chk("R6 master marks zero", int'(sync_out), 1);

    // R11: compare at zero beats zero action; no-action code does not mask.
    cmpa_wr = 1; cmpa_wdata = 0;
    cyc();
    measure(0, 0, n, ha, hb);
    measure(0, 0, n, ha, hb);
    chk("R11 A clear beats zero set", ha, 0);
    chk("R11 B no-action does not mask set", hb, 12);

    // R4: invert code at zero alternates whole periods.
    act_a = 10'b00_00_00_00_11;
    measure(0, 0, n, ha, hb);
    measure(0, 0, n, ha2, hb2);
    chk("R4 invert sum", ha + ha2, 12);
    chk("R4 invert alternates", int'(ha != ha2), 1);

    // Random mix against the reference model.
    for (int it = 0; it < 6000; it++) begin
      if (it % 128 == 0) begin
        act_a = 10'($urandom % 1024);
        act_b = 10'($urandom % 1024);
        sync_master = 1'($urandom % 2);
      end
      tb_en     = ($urandom % 16) != 0;
      sync_in   = ($urandom % 23) == 0;
      phase_en  = 1'($urandom % 2);
      phase_val = CW'($urandom % 10);
      if ($urandom % 97 == 0) begin cnt_wr = 1; cnt_wdata = CW'($urandom % 12); end
      if ($urandom % 40 == 0) begin prd_wr = 1; prd_wdata = CW'($urandom % 10); end
      if ($urandom % 30 == 0) begin cmpa_wr = 1; cmpa_wdata = CW'($urandom % 11); end
      if ($urandom % 30 == 0) begin cmpb_wr = 1; cmpb_wdata = CW'($urandom % 11); end
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule